// File: doc/BRIEF.md
# Matrix Keypad Scanner with Event Queue

This block scans a small key matrix of four rows and three columns, filters each key against contact bounce, and turns every accepted change of a key into a one-byte event. It drives one column low at a time and reads the active-low row lines. Each key has a fixed slot in the scan, so each slot decides on one key.

Events go into a ten-entry queue. A host reads the queue through a pop strobe and sees how many entries are waiting. An active-low interrupt line tells the host that events are pending. A clear strobe drops the interrupt when the queue is empty. If the host asserts clear while events are still queued, the line only releases for 50 µs and then asserts again. This reminds a host that cleared too early.

Top module: `kpd_matrix_top`

## Requirements
- R1: Exactly one column output is low at any time. Columns are visited in the order 0, 1, 2, and each stays low for ROWS*SCAN_DIV clock cycles. Column 0 is driven first after reset.
- R2: A press of the key at row r and column c queues the event byte 10*r + c + 1, with bit 7 clear. Row 0 gives 1 to 3 and row 3 gives 31 to 33.
- R3: A release queues the same code with bit 7 set (0x80 | code).
- R4: A key changes its accepted state only when two consecutive scans of that key agree on the new level. A press that lasts less than one full sweep of the matrix queues no event.
- R5: Events are popped oldest first. The popped byte appears on rd_data one clock after the pop strobe, and rd_data holds that value until the next pop.
- R6: The queue holds 10 events. An event that arrives while the queue is full is dropped and sets the overflow flag. The flag stays set until a clear strobe.
- R7: A pop while the queue is empty returns 0x00 and leaves the count at 0.
- R8: evt_count shows the number of queued events. It changes one clock after a push or pop.
- R9: An accepted event sets an interrupt status. int_n is low while that status is set and the queue is not empty, and int_n is high when the queue is empty. A clear strobe with an empty queue clears the status.
- R10: A clear strobe with events still queued keeps the status set. int_n goes high for exactly CLK_MHZ*50 cycles (50 µs) and then goes low again.
- R11: After reset, int_n is high, evt_count is 0, the overflow flag is 0, rd_data is 0x00 and column 0 is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rows_n | input | ROWS | Row sense lines, low when a key in the driven column is pressed |
| col_n | output | COLS | Column drive lines, one low at a time |
| pop | input | 1 | Strobe that reads one event from the queue |
| clr | input | 1 | Strobe that clears the interrupt and the overflow flag |
| rd_data | output | 8 | Last popped event byte (bit 7 = release, bits 6:0 = key code) |
| evt_count | output | $clog2(DEPTH+1) | Number of queued events |
| ovf | output | 1 | Sticky flag: an event was dropped because the queue was full |
| int_n | output | 1 | Interrupt line, active low |

## Verification
The pop result and the count are due one clock after the edge that takes the strobe. int_n follows on that same edge. A key change reaches the queue only after two samples that are one sweep apart, so the bench waits three full sweeps after it changes the key model before it reads anything. The deassert pulse is checked on its first cycle, on its last cycle, and on the cycle after it ends. Inputs change on the falling edge and outputs are sampled on the falling edge, halfway between the register updates.

// File: rtl/kpd_pkg.sv
package kpd_pkg;

    typedef struct packed {
        logic       rel;
        logic [6:0] code;
    } kpd_evt_t;

    function automatic logic [6:0] kpd_code(input int row, input int col);
        return 7'(row * 10 + col + 1);
    endfunction

endpackage

// File: rtl/kpd_scan.sv
module kpd_scan
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 3,
    parameter int SCAN_DIV = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] rows_n,
    output logic [COLS-1:0] col_n,
    output logic            evt_valid,
    output kpd_evt_t        evt
);

    localparam int KEYS  = ROWS * COLS;
    localparam int KEY_W = (KEYS > 1) ? $clog2(KEYS) : 1;
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [ROWS-1:0]  sync1;
        logic [ROWS-1:0]  sync2;
        logic [KEYS-1:0]  prev;
        logic [KEYS-1:0]  stable;
        logic             evt_valid;
        kpd_evt_t         evt;
    } scan_t;

    scan_t            q, d;
    logic [KEY_W-1:0] idx;
    logic             hit;

    always_comb begin
        d           = q;
        d.sync1     = ~rows_n;
        d.sync2     = q.sync1;
        d.evt_valid = 1'b0;
        idx         = KEY_W'(int'(q.row) * COLS + int'(q.col));
        hit         = q.sync2[q.row];
        if (q.div == DIV_W'(SCAN_DIV - 1)) begin
            d.div = '0;
            if (hit == q.prev[idx] && hit != q.stable[idx]) begin
                d.stable[idx] = hit;
                d.evt_valid   = 1'b1;
                d.evt.rel     = ~hit;
                d.evt.code    = kpd_code(int'(q.row), int'(q.col));
            end
            d.prev[idx] = hit;
            if (q.row == ROW_W'(ROWS - 1)) begin
                d.row = '0;
                d.col = (q.col == COL_W'(COLS - 1)) ? '0 : COL_W'(q.col + 1'b1);
            end else begin
                d.row = ROW_W'(q.row + 1'b1);
            end
        end else begin
            d.div = DIV_W'(q.div + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_n[c] = (q.col != COL_W'(c));
    end

    assign evt_valid = q.evt_valid;
    assign evt       = q.evt;

endmodule

// File: rtl/kpd_fifo.sv
module kpd_fifo #(
    parameter int DEPTH = 10,
    parameter int W     = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    input  logic             clr,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             pushed
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
        logic [W-1:0]            rd_data;
        logic                    ovf;
    } fifo_t;

    fifo_t q, d;
    logic  do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CNT_W'(DEPTH)) || do_pop);
        if (pop) begin
            d.rd_data = do_pop ? q.mem[q.rd] : '0;
        end
        if (do_pop) begin
            d.rd = (q.rd == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(q.rd + 1'b1);
        end
        if (do_push) begin
            d.mem[q.wr] = push_data;
            d.wr = (q.wr == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(q.wr + 1'b1);
        end
        d.cnt = CNT_W'(q.cnt + CNT_W'(do_push) - CNT_W'(do_pop));
        if (clr) d.ovf = 1'b0;
        if (push && !do_push) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.rd_data;
    assign count   = q.cnt;
    assign ovf     = q.ovf;
    assign pushed  = do_push;

endmodule

// File: rtl/kpd_irq.sv
module kpd_irq #(
    parameter int PULSE_CYC = 5000,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pushed,
    input  logic             clr,
    input  logic [CNT_W-1:0] count,
    output logic             int_n
);

    localparam int PW = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic          stat;
        logic [PW-1:0] pulse;
    } irq_t;

    irq_t q, d;

    always_comb begin
        d = q;
        if (q.pulse != '0) d.pulse = PW'(q.pulse - 1'b1);
        if (clr) begin
            if (count != '0) d.pulse = PW'(PULSE_CYC);
            else             d.stat  = 1'b0;
        end
        if (pushed) d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign int_n = !(q.stat && (count != '0) && (q.pulse == '0));

endmodule

// File: rtl/kpd_matrix_top.sv
module kpd_matrix_top
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 3,
    parameter int SCAN_DIV = 1000,
    parameter int DEPTH    = 10,
    parameter int CLK_MHZ  = 100,
    parameter int PULSE_US = 50
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ROWS-1:0]              rows_n,
    output logic [COLS-1:0]              col_n,
    input  logic                         pop,
    input  logic                         clr,
    output logic [7:0]                   rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   evt_count,
    output logic                         ovf,
    output logic                         int_n
);

    localparam int CNT_W     = $clog2(DEPTH + 1);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

    logic     evt_valid;
    kpd_evt_t evt;
    logic     pushed;

    kpd_scan #(
        .ROWS(ROWS), .COLS(COLS), .SCAN_DIV(SCAN_DIV)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .rows_n(rows_n), .col_n(col_n),
        .evt_valid(evt_valid), .evt(evt)
    );

    kpd_fifo #(
        .DEPTH(DEPTH), .W(8), .CNT_W(CNT_W)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(evt_valid), .push_data(evt),
        .pop(pop), .clr(clr), .rd_data(rd_data), .count(evt_count),
        .ovf(ovf), .pushed(pushed)
    );

    kpd_irq #(
        .PULSE_CYC(PULSE_CYC), .CNT_W(CNT_W)
    ) u_irq (
        .clk(clk), .rst_n(rst_n), .pushed(pushed), .clr(clr),
        .count(evt_count), .int_n(int_n)
    );

endmodule

// File: rtl/kpd_matrix_chk.sv
module kpd_matrix_chk #(
    parameter int COLS  = 3,
    parameter int DEPTH = 10,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [COLS-1:0]  col_n,
    input logic             pop,
    input logic             clr,
    input logic [7:0]       rd_data,
    input logic [CNT_W-1:0] evt_count,
    input logic             ovf,
    input logic             int_n
);

    // R1: a single column driven
    a_r1_one_col: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_n) == 1);

    // R8: count never exceeds capacity
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        evt_count <= CNT_W'(DEPTH));

    // R6: full queue stays full without a pop
    a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count == CNT_W'(DEPTH)) && !pop |=> evt_count == CNT_W'(DEPTH));

    // R6: overflow flag is sticky until clear
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !clr |=> ovf);

    // R7: pop on empty yields zero
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop && (evt_count == '0) |=> rd_data == 8'h00);

    // R5: a pop never grows the count
    a_r5_pop_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        pop && (evt_count != '0) |=> evt_count <= $past(evt_count));

    // R9: empty queue keeps the line high
    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count == '0) |-> int_n);

    // R10: early clear releases the line on the next cycle
    a_r10_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        clr && (evt_count != '0) |=> int_n);

endmodule

bind kpd_matrix_top kpd_matrix_chk #(
    .COLS(COLS), .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .pop(pop), .clr(clr),
    .rd_data(rd_data), .evt_count(evt_count), .ovf(ovf), .int_n(int_n)
);

// File: tb/kpd_matrix_top_bench.sv
module kpd_matrix_top_bench;

    localparam int ROWS  = 4;
    localparam int COLS  = 3;
    localparam int DIV   = 4;
    localparam int DEPTH = 10;
    localparam int SWEEP = ROWS * COLS * DIV;
    localparam int PULSE = 100 * 50;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [ROWS-1:0] rows_n;
    logic [COLS-1:0] col_n;
    logic            pop = 1'b0;
    logic            clr = 1'b0;
    logic [7:0]      rd_data;
    logic [3:0]      evt_count;
    logic            ovf;
    logic            int_n;
    logic            keys [ROWS][COLS];

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    kpd_matrix_top #(
        .ROWS(ROWS), .COLS(COLS), .SCAN_DIV(DIV), .DEPTH(DEPTH)
    ) u_kpd_matrix_top (
        .clk(clk), .rst_n(rst_n), .rows_n(rows_n), .col_n(col_n),
        .pop(pop), .clr(clr), .rd_data(rd_data), .evt_count(evt_count),
        .ovf(ovf), .int_n(int_n)
    );

    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            rows_n[r] = 1'b1;
            for (int c = 0; c < COLS; c++)
                if (keys[r][c] && !col_n[c]) rows_n[r] = 1'b0;
        end
    end

    function automatic int exp_code(input int r, input int c);
        return 10 * r + c + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    task automatic set_all(input bit v);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) keys[r][c] = v;
    endtask

    task automatic wait_sweeps(input int n);
        repeat (n * SWEEP) @(negedge clk);
    endtask

    task automatic align_sweep();
        logic [COLS-1:0] pc;
        pc = col_n;
        forever begin
            @(negedge clk);
            if (pc == 3'b011 && col_n == 3'b110) break;
            pc = col_n;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, k, r, c, code;
        int order [12];
        void'($urandom(32'd2024));
        set_all(1'b0);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(int_n == 1'b1, "R11 int_n", int'(int_n), 1);
        check(evt_count == 0, "R11 count", int'(evt_count), 0);
        check(ovf == 1'b0, "R11 ovf", int'(ovf), 0);
        check(rd_data == 8'h00, "R11 rd_data", int'(rd_data), 0);
        check(col_n == 3'b110, "R11 col", int'(col_n), 6);
        rst_n = 1'b1;

        // R1: column order and dwell
        while (col_n == 3'b110) @(negedge clk);
        check(col_n == 3'b101, "R1 second col", int'(col_n), 5);
        n = 0;
        while (col_n == 3'b101) begin n++; @(negedge clk); end
        check(n == ROWS * DIV, "R1 dwell", n, ROWS * DIV);
        check(col_n == 3'b011, "R1 third col", int'(col_n), 3);

        // R7: pop on empty
        do_pop();
        check(rd_data == 8'h00, "R7 empty data", int'(rd_data), 0);
        check(evt_count == 0, "R7 empty count", int'(evt_count), 0);

        // R2 R3 R9: random single keys
        for (int i = 0; i < 8; i++) begin
            k = $urandom_range(11);
            r = k / COLS;
            c = k % COLS;
            code = exp_code(r, c);
            @(negedge clk) keys[r][c] = 1'b1;
            wait_sweeps(3);
            check(evt_count == 1, "R8 count after press", int'(evt_count), 1);
            check(int_n == 1'b0, "R9 int asserted", int'(int_n), 0);
            do_pop();
            check(rd_data == 8'(code), "R2 press code", int'(rd_data), code);
            check(int_n == 1'b1, "R9 int high when empty", int'(int_n), 1);
            @(negedge clk) keys[r][c] = 1'b0;
            wait_sweeps(3);
            do_pop();
            check(rd_data == 8'(code | 8'h80), "R3 release code", int'(rd_data), code | 128);
            do_clr();
        end

        // R4: press shorter than a sweep is ignored
        @(negedge clk) keys[2][1] = 1'b1;
        repeat (SWEEP - 8) @(negedge clk);
        keys[2][1] = 1'b0;
        wait_sweeps(3);
        check(evt_count == 0, "R4 short press ignored", int'(evt_count), 0);

        // R5 R6 R8: all keys at once, aligned to the sweep start
        align_sweep();
        set_all(1'b1);
        wait_sweeps(3);
        check(evt_count == DEPTH, "R8 full count", int'(evt_count), DEPTH);
        check(ovf == 1'b1, "R6 overflow set", int'(ovf), 1);
        n = 0;
        for (int cc = 0; cc < COLS; cc++)
            for (int rr = 0; rr < ROWS; rr++) begin
                order[n] = exp_code(rr, cc);
                n++;
            end
        for (int i = 0; i < DEPTH; i++) begin
            do_pop();
            check(rd_data == 8'(order[i]), "R5 fifo order", int'(rd_data), order[i]);
        end
        check(ovf == 1'b1, "R6 overflow sticky", int'(ovf), 1);
        do_pop();
        check(rd_data == 8'h00, "R7 drained pop", int'(rd_data), 0);
        do_clr();
        check(ovf == 1'b0, "R6 overflow cleared", int'(ovf), 0);

        // R10: early clear pulse
        set_all(1'b0);
        wait_sweeps(3);
        check(evt_count == DEPTH, "R8 refill count", int'(evt_count), DEPTH);
        check(int_n == 1'b0, "R9 int before clear", int'(int_n), 0);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        check(int_n == 1'b1, "R10 pulse start", int'(int_n), 1);
        repeat (PULSE - 1) @(negedge clk);
        check(int_n == 1'b1, "R10 pulse last cycle", int'(int_n), 1);
        @(negedge clk);
        check(int_n == 1'b0, "R10 reasserted", int'(int_n), 0);
        for (int i = 0; i < DEPTH; i++) do_pop();
        check(evt_count == 0, "R8 drained", int'(evt_count), 0);
        check(int_n == 1'b1, "R9 high after drain", int'(int_n), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule